// File: doc/BRIEF.md
# Parallel Printer Port Register Set

This block is the host-side register set of a classic parallel printer port, sitting on a small synchronous CPU bus. The bus has a 2-bit offset, an active-low write strobe and a read data path. A write takes effect when the strobe returns high. A small state machine tracks the strobe through three states. `WS_IDLE` waits for the strobe to go low (transition IDLE→LOW). `WS_LOW` waits for it to rise, and at that moment captures offset and byte (transition LOW→COMMIT). `WS_COMMIT` applies the captured write for one clock, then returns to `WS_IDLE`, or to `WS_LOW` if the strobe is already low again.

A data register drives the eight port data pins. Reads of the data offset return the live level of the pins. A status byte is assembled from the printer status inputs after a synchronizer. A control register drives the four active-low printer control outputs, the acknowledge-interrupt enable and the transfer direction.

A mode input picks plain data-port behaviour or a forward FIFO mode. In the forward FIFO mode, bytes written to offset 0 are queued with a tag marking them as address/run-length items. The item is not placed in the data register. The consumer of the queue pops entries through a simple pop/empty interface.

Top module: `pport_regs`

## Requirements
- R1: After reset the port data outputs are 0, the control register is 0 (`ctl_strobe_n`=1, `ctl_linefeed_n`=1, `ctl_reset_n`=0, `ctl_select_n`=1), the queue is empty, the overflow flag is 0 and `irq` is 0.
- R2: In mode 3'b000 or 3'b001, a write to offset 0 loads the byte into the data register, and `port_dout` shows it within three clocks after `wr_n` rises. While `wr_n` stays low, `port_dout` does not change.
- R3: A read of offset 0 returns the level on `port_din`, not the stored data byte.
- R4: A read of offset 1 returns bits 2:0 = 0, bit 3 = `st_error_n`, bit 4 = `st_online`, bit 5 = `st_paper_out`, bit 6 = `st_ack_n`, and bit 7 = the inverse of `st_busy`.
- R5: A write to offset 2 stores bits 5:0 of the byte. A read of offset 2 returns those six bits, with bits 7:6 = 0. Bit 4 is the interrupt enable and bit 5 is the direction (0 = forward).
- R6: Control bit 0 drives `ctl_strobe_n` inverted, bit 1 drives `ctl_linefeed_n` inverted, bit 2 drives `ctl_reset_n` as is, and bit 3 drives `ctl_select_n` inverted.
- R7: In mode 3'b011 with direction 0, a write to offset 0 appends {1'b1, byte} to the queue (tag in bit 8). The data register is left unchanged. Entries leave the queue in write order, and `fifo_dout` always shows the oldest entry.
- R8: In mode 3'b011 with direction 1, a write to offset 0 changes neither the queue nor `port_dout`.
- R9: The queue holds FIFO_DEPTH entries. A queue write while `fifo_full` is high is dropped and sets `fifo_ovf`, which then stays set until reset.
- R10: `irq` goes high for exactly one clock after each falling edge of the synchronized `st_ack_n`, and only while control bit 4 is 1.
- R11: Status inputs pass through SYNC_STAGES flops. A change shows in the offset 1 read after exactly SYNC_STAGES clock edges.
- R12: A read of offset 3 returns 0. A write to offset 3 changes neither the control register nor `port_dout`.
- R13: In modes other than 3'b000, 3'b001 and 3'b011, a write to offset 0 changes neither the data register nor the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register offset |
| wr_n | input | 1 | Active-low write strobe; write commits on its rise |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the current offset |
| port_mode | input | 3 | Port mode code |
| port_dout | output | 8 | Data pins driven by the data register |
| port_din | input | 8 | Level sensed on the data pins |
| st_error_n | input | 1 | Printer error, active low |
| st_online | input | 1 | Printer selected/online |
| st_paper_out | input | 1 | Paper empty |
| st_ack_n | input | 1 | Acknowledge, active low |
| st_busy | input | 1 | Printer busy |
| ctl_strobe_n | output | 1 | Data strobe, active low |
| ctl_linefeed_n | output | 1 | Auto line feed, active low |
| ctl_reset_n | output | 1 | Printer initialise, active low |
| ctl_select_n | output | 1 | Printer select, active low |
| irq | output | 1 | One-clock acknowledge interrupt pulse |
| fifo_pop | input | 1 | Remove the oldest queue entry |
| fifo_dout | output | 9 | Oldest queue entry, tag in bit 8 |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| fifo_ovf | output | 1 | Sticky queue overflow |

## Verification
The bench uses the defaults FIFO_DEPTH=16 and SYNC_STAGES=2. With these values, the queue fills after sixteen writes, so the dropped seventeenth write and the sticky overflow are reached within a short directed run. A two-stage synchronizer gives a fixed two-edge delay, so the bench can sample the status byte on the exact edge where it must still hold the old value and on the one where it must show the new value. Seeded random sequences of writes, reads and pops across the three defined modes and both directions are run against a reference model of the register set and the queue.

// File: rtl/pport_pkg.sv
package pport_pkg;
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_LOW    = 2'd1,
        WS_COMMIT = 2'd2
    } wstate_e;

    localparam logic [1:0] OFS_DATA   = 2'd0;
    localparam logic [1:0] OFS_STATUS = 2'd1;
    localparam logic [1:0] OFS_CTRL   = 2'd2;
    localparam logic [1:0] OFS_SPARE  = 2'd3;

    localparam logic [2:0] MODE_COMPAT   = 3'b000;
    localparam logic [2:0] MODE_BIDIR    = 3'b001;
    localparam logic [2:0] MODE_FIFO_FWD = 3'b011;

    localparam int CTRL_W   = 6;
    localparam int BIT_IEN  = 4;
    localparam int BIT_DIR  = 5;
    localparam int STAT_W   = 5;
endpackage

// File: rtl/pport_wr_fsm.sv
module pport_wr_fsm
    import pport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic       commit,
    output logic [1:0] c_addr,
    output logic [7:0] c_data
);
    wstate_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:   if (!wr_n) state_d = WS_LOW;
            WS_LOW:    if (wr_n)  state_d = WS_COMMIT;
            WS_COMMIT: state_d = wr_n ? WS_IDLE : WS_LOW;
            default:   state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_addr <= '0;
            c_data <= '0;
        end else if (state_q == WS_LOW && wr_n) begin
            c_addr <= addr;
            c_data <= wdata;
        end
    end

    always_comb begin
        commit = (state_q == WS_COMMIT);
    end
endmodule

// File: rtl/pport_status_sync.sv
module pport_status_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= rst_val;
                else        stg[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= rst_val;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/pport_tag_fifo.sv
module pport_tag_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic         do_push, do_pop;

    assign empty   = (wp == rp);
    assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            ovf <= 1'b0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            if (push && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr_n,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [2:0] port_mode,
    output logic [7:0] port_dout,
    input  logic [7:0] port_din,
    input  logic       st_error_n,
    input  logic       st_online,
    input  logic       st_paper_out,
    input  logic       st_ack_n,
    input  logic       st_busy,
    output logic       ctl_strobe_n,
    output logic       ctl_linefeed_n,
    output logic       ctl_reset_n,
    output logic       ctl_select_n,
    output logic       irq,
    input  logic       fifo_pop,
    output logic [8:0] fifo_dout,
    output logic       fifo_empty,
    output logic       fifo_full,
    output logic       fifo_ovf
);
    logic              wr_commit;
    logic [1:0]        c_addr;
    logic [7:0]        c_data;
    logic [7:0]        data_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_raw, stat_s;
    logic              ack_prev;
    logic              data_mode, push;

    pport_wr_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .wdata  (wdata),
        .commit (wr_commit),
        .c_addr (c_addr),
        .c_data (c_data)
    );

    // order: busy, ack_n, paper_out, online, error_n
    assign stat_raw = {st_busy, st_ack_n, st_paper_out, st_online, st_error_n};

    pport_status_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (stat_raw),
        .rst_val (5'b01001),
        .dout    (stat_s)
    );

    assign data_mode = (port_mode == MODE_COMPAT) || (port_mode == MODE_BIDIR);
    assign push = wr_commit && (c_addr == OFS_DATA) &&
                  (port_mode == MODE_FIFO_FWD) && !ctrl_q[BIT_DIR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ctrl_q <= '0;
        end else if (wr_commit) begin
            unique case (c_addr)
                OFS_DATA:   if (data_mode) data_q <= c_data;
                OFS_CTRL:   ctrl_q <= c_data[CTRL_W-1:0];
                OFS_STATUS,
                OFS_SPARE:  ;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ack_prev <= 1'b1;
        else        ack_prev <= stat_s[3];
    end

    assign irq = ctrl_q[BIT_IEN] && ack_prev && !stat_s[3];

    pport_tag_fifo #(.DEPTH(FIFO_DEPTH), .W(9)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({1'b1, c_data}),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .ovf   (fifo_ovf)
    );

    always_comb begin
        unique case (addr)
            OFS_DATA:   rdata = port_din;
            OFS_STATUS: rdata = {~stat_s[4], stat_s[3], stat_s[2], stat_s[1], stat_s[0], 3'b000};
            OFS_CTRL:   rdata = {2'b00, ctrl_q};
            default:    rdata = 8'h00;
        endcase
    end

    assign port_dout      = data_q;
    assign ctl_strobe_n   = ~ctrl_q[0];
    assign ctl_linefeed_n = ~ctrl_q[1];
    assign ctl_reset_n    = ctrl_q[2];
    assign ctl_select_n   = ~ctrl_q[3];
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_commit,
    input logic [1:0] c_addr,
    input logic [2:0] c_lo,
    input logic [7:0] port_dout,
    input logic       ctl_strobe_n,
    input logic       ctl_linefeed_n,
    input logic       ctl_reset_n,
    input logic       irq,
    input logic [5:0] ctrl_q,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       fifo_ovf
);
    a_r2_dout_moves_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(port_dout));

    a_r6_ctrl_pin_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && c_addr == 2'd2) |=>
            (ctl_strobe_n == !$past(c_lo[0])) && (ctl_linefeed_n == !$past(c_lo[1])) &&
            (ctl_reset_n == $past(c_lo[2])));

    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q[4]);

    a_r10_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf |=> fifo_ovf);

    a_r9_full_excludes_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r12_spare_offset_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && c_addr == 2'd3) |=> $stable(ctrl_q) && $stable(port_dout));
endmodule

bind pport_regs pport_regs_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_commit      (wr_commit),
    .c_addr         (c_addr),
    .c_lo           (c_data[2:0]),
    .port_dout      (port_dout),
    .ctl_strobe_n   (ctl_strobe_n),
    .ctl_linefeed_n (ctl_linefeed_n),
    .ctl_reset_n    (ctl_reset_n),
    .irq            (irq),
    .ctrl_q         (ctrl_q),
    .fifo_full      (fifo_full),
    .fifo_empty     (fifo_empty),
    .fifo_ovf       (fifo_ovf)
);

// File: tb/pport_regs_test.sv
module pport_regs_test;
    localparam int DEPTH = 16;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] port_mode = 3'b000;
    logic [7:0] port_dout;
    logic [7:0] port_din = '0;
    logic       st_error_n = 1'b1, st_online = 1'b0, st_paper_out = 1'b0;
    logic       st_ack_n = 1'b1, st_busy = 1'b0;
    logic       ctl_strobe_n, ctl_linefeed_n, ctl_reset_n, ctl_select_n, irq;
    logic       fifo_pop = 1'b0;
    logic [8:0] fifo_dout;
    logic       fifo_empty, fifo_full, fifo_ovf;

    pport_regs #(.FIFO_DEPTH(DEPTH), .SYNC_STAGES(SYNC)) uut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] m_data = '0;
    logic [5:0] m_ctrl = '0;
    logic [8:0] m_q[$];
    bit         m_ovf = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic e, input logic o, input logic p,
                                              input logic a, input logic b);
        return {~b, a, p, o, e, 3'b000};
    endfunction

    function automatic logic [3:0] exp_pins(input logic [5:0] c);
        return {~c[3], c[2], ~c[1], ~c[0]};   // select_n, reset_n, linefeed_n, strobe_n
    endfunction

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        if (a == 2'd0) begin
            if (port_mode == 3'b000 || port_mode == 3'b001) m_data = d;
            else if (port_mode == 3'b011 && !m_ctrl[5]) begin
                if (m_q.size() < DEPTH) m_q.push_back({1'b1, d});
                else m_ovf = 1'b1;
            end
        end else if (a == 2'd2) m_ctrl = d[5:0];
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check_all(input string req);
        logic [7:0] r;
        check({req, " port_dout"}, port_dout, m_data);
        check({req, " ctl pins"}, {ctl_select_n, ctl_reset_n, ctl_linefeed_n, ctl_strobe_n},
              exp_pins(m_ctrl));
        bus_read(2'd2, r);
        check({req, " ctrl read"}, r, {2'b00, m_ctrl});
        check({req, " fifo_empty"}, fifo_empty, m_q.size() == 0);
        check({req, " fifo_full"}, fifo_full, m_q.size() == DEPTH);
        check({req, " fifo_ovf"}, fifo_ovf, m_ovf);
        if (m_q.size() != 0) check({req, " fifo_dout"}, fifo_dout, m_q[0]);
    endtask

    task automatic do_pop();
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
        if (m_q.size() != 0) void'(m_q.pop_front());
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int         irq_cnt;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_all("R1");
        check("R1 irq", irq, 1'b0);

        // R2 data write in compatible mode, held-low strobe has no effect
        port_mode = 3'b000;
        addr = 2'd0; wdata = 8'hA5; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 held low", port_dout, 8'h00);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        model_write(2'd0, 8'hA5);
        check_all("R2 mode000");
        port_mode = 3'b001;
        bus_write(2'd0, 8'h5A);
        check_all("R2 mode001");

        // R3 read of offset 0 gives pin level
        port_din = 8'h3C;
        bus_read(2'd0, r);
        check("R3 pin read", r, 8'h3C);

        // R4 and R11 status layout and latency
        for (int k = 0; k < 4; k++) begin
            logic [4:0] v, old;
            old = {st_busy, st_ack_n, st_paper_out, st_online, st_error_n};
            v = (k == 0) ? 5'b10110 : (k == 1) ? 5'b01001 : (k == 2) ? 5'b11111 : 5'b00000;
            @(negedge clk);
            {st_busy, st_ack_n, st_paper_out, st_online, st_error_n} = v;
            repeat (SYNC - 1) @(negedge clk);
            bus_read(2'd1, r);
            check("R11 not yet", r, exp_status(old[0], old[1], old[2], old[3], old[4]));
            @(negedge clk);
            bus_read(2'd1, r);
            check("R4 status", r, exp_status(v[0], v[1], v[2], v[3], v[4]));
        end
        st_ack_n = 1'b1;

        // R5 and R6 control register
        bus_write(2'd2, 8'hFF);
        check_all("R5 ctrl ff");
        bus_write(2'd2, 8'h0A);
        check_all("R6 ctrl 0a");
        bus_write(2'd2, 8'h05);
        check_all("R6 ctrl 05");

        // R12 spare offset
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, r);
        check("R12 read", r, 8'h00);
        check_all("R12 write ignored");

        // R13 undefined mode
        port_mode = 3'b010;
        bus_write(2'd0, 8'h77);
        check_all("R13 mode010");
        port_mode = 3'b110;
        bus_write(2'd0, 8'h66);
        check_all("R13 mode110");

        // R8 reverse direction in FIFO mode
        port_mode = 3'b011;
        bus_write(2'd2, 8'h20);
        bus_write(2'd0, 8'h99);
        check_all("R8 reverse");

        // R7 and R9 fill, overflow, drain
        bus_write(2'd2, 8'h00);
        for (int i = 0; i < DEPTH + 1; i++) bus_write(2'd0, 8'(8'h10 + i));
        check_all("R9 full ovf");
        bus_write(2'd2, 8'h04);
        check_all("R9 ovf sticky");
        while (m_q.size() != 0) begin
            check("R7 order", fifo_dout, m_q[0]);
            do_pop();
        end
        check_all("R7 drained");

        // R10 interrupt gating
        for (int en = 0; en < 2; en++) begin
            bus_write(2'd2, en ? 8'h10 : 8'h00);
            @(negedge clk);
            st_ack_n = 1'b0;
            irq_cnt = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (irq) irq_cnt++;
            end
            check(en ? "R10 enabled" : "R10 disabled", irq_cnt, en);
            st_ack_n = 1'b1;
            repeat (4) @(negedge clk);
        end

        // random mix across R2 R5 R7 R8 R9
        for (int it = 0; it < 80; it++) begin
            int sel;
            sel = $urandom_range(0, 5);
            case ($urandom_range(0, 2))
                0: port_mode = 3'b000;
                1: port_mode = 3'b001;
                default: port_mode = 3'b011;
            endcase
            if (sel == 5) begin
                do_pop();
            end else begin
                logic [1:0] a;
                a = (sel < 3) ? 2'd0 : 2'(sel == 3 ? 2 : $urandom_range(1, 3));
                bus_write(a, 8'($urandom()) & (a == 2'd2 ? 8'hEF : 8'hFF));
            end
            check_all("R7 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule